// File: doc/BRIEF.md
# Fixed-Point Q-Format Conversion Unit

This block converts and packs signed fractional (Q-format) and integer values held in 64-bit vector registers. Each operation takes an operation code, up to two 64-bit sources and the current 64-bit value of the destination, and produces a new 64-bit destination value. It is used in the execute stage of a vector pipeline, next to a register file that supplies the operands and takes the result back.

It supports the following groups of operations:
- **Widening** conversions, from Q15 to Q30 and from Q31 to Q62.
- **Narrowing** conversions, from Q62 to Q15 and from Q62 to Q31. These round, then saturate, and write only the low lane of the destination.
- **Pack** operations, which narrow two sources lane by lane and merge them into one word.

Any lane that clamps raises a per-operation saturation output and a sticky saturation flag. With the default setting the result is registered, and an operation issued with `op_valid` is visible one clock later.

Top module: `qcv_unit`

## Requirements
- R1: Operation 0 sign-extends source A bits 15:0 to 64 bits and shifts the value left by 15. Result bits 14:0 are zero.
- R2: Operation 1 sign-extends source A bits 31:0 to 64 bits and shifts the value left by 31.
- R3: Operation 2 treats source A as Q62, rounds it to Q15, and saturates it to a signed 16-bit value placed in result bits 15:0. Result bits 63:16 equal destination-in bits 63:16.
- R4: Operation 3 treats source A as Q62, rounds it to Q31, and saturates it to a signed 32-bit value placed in result bits 31:0. Result bits 63:32 equal destination-in bits 63:32.
- R5: Operation 4 takes four 32-bit lanes in this order: A low word, A high word, B low word, B high word. It rounds each lane from Q31 to Q15, saturates it to 16 bits, and places the results in halfwords 0, 1, 2 and 3.
- R6: Operation 5 saturates the whole of source A to a signed 32-bit value in result bits 31:0, and the whole of source B to a signed 32-bit value in bits 63:32.
- R7: Operation 6 doubles each whole 64-bit source without losing its top bit, then saturates it to signed 32 bits. A goes to the low word and B to the high word.
- R8: Rounding adds one half of the target LSB before an arithmetic right shift, so an exact half always rounds toward plus infinity. The sum is formed one bit wider than the source, so it cannot wrap.
- R9: A clamped 16-bit lane becomes 0x7FFF or 0x8000, and a clamped 32-bit lane becomes 0x7FFFFFFF or 0x80000000. `sat` is 1 exactly when some lane of the operation clamped. It is always 0 for operations 0, 1 and 7.
- R10: `sat_sticky` is set by any issued operation that clamps. It stays at 1 until reset.
- R11: Operation 7 is illegal. It returns destination-in unchanged, with `illegal` at 1 and `sat` at 0.
- R12: With REG_OUT=1, outputs change only at the clock edge where `op_valid` is 1. They hold their value while `op_valid` is 0.
- R13: Synchronous reset clears `result`, `sat`, `illegal` and `sat_sticky` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for the operation on the inputs |
| op | input | 3 | Operation code, values 0 to 7 as listed in the requirements |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| dst_in | input | 64 | Current destination value |
| result | output | 64 | New destination value |
| sat | output | 1 | Some lane of the last operation clamped |
| sat_sticky | output | 1 | Accumulated saturation flag |
| illegal | output | 1 | Last operation code was illegal |

## Verification
The assertions assume the default registered output. They also assume that `op`, the sources and `dst_in` are stable around each rising edge. Every operation code is treated as meaningful, including the illegal one, so no input value is excluded.

The stimulus changes inputs only on the falling edge. It raises `op_valid` for exactly one edge per operation, then lowers it before the hold check. Operands are picked at the saturation limits, at exact half-LSB points, and at the most negative 64-bit value, so that rounding and clamping are exercised where they flip.

// File: rtl/qcv_pkg.sv
package qcv_pkg;

    localparam int unsigned DW  = 64;
    localparam int unsigned HW  = DW / 2;
    localparam int unsigned QW  = DW / 4;
    localparam int unsigned OPW = 3;

    // Fractional bits of each format, relative to the word widths
    localparam int unsigned FRAC_Q15 = QW - 1;
    localparam int unsigned FRAC_Q31 = HW - 1;
    localparam int unsigned FRAC_Q62 = DW - 2;

    typedef enum logic [OPW-1:0] {
        QOP_WIDEN_H   = 3'd0,
        QOP_WIDEN_W   = 3'd1,
        QOP_NARROW_H  = 3'd2,
        QOP_NARROW_W  = 3'd3,
        QOP_PACK_RND  = 3'd4,
        QOP_PACK_INT  = 3'd5,
        QOP_PACK_DBL  = 3'd6,
        QOP_RESERVED  = 3'd7
    } qop_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          clamp;
        logic          illegal;
    } qres_t;

    function automatic logic clamps_possible(input qop_e o);
        return !(o == QOP_WIDEN_H || o == QOP_WIDEN_W || o == QOP_RESERVED);
    endfunction

endpackage

// File: rtl/qcv_lane_sat.sv
// One lane: optional doubling, round-half-up drop of DROP bits, signed clamp.
module qcv_lane_sat #(
    parameter int IN_W    = 32,
    parameter int DROP    = 16,
    parameter int OUT_W   = 16,
    parameter int PRE_SHL = 0
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout,
    output logic             clamp
);
    localparam int EW = IN_W + PRE_SHL + 1;

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] scaled;
    logic [EW-OUT_W:0]    upper;

    assign ext = signed'({{(PRE_SHL+1){din[IN_W-1]}}, din}) <<< PRE_SHL;

    generate
        if (DROP > 0) begin : g_round
            localparam logic signed [EW-1:0] HALF = EW'(1) << (DROP - 1);
            logic signed [EW-1:0] summed;
            assign summed = ext + HALF;
            assign scaled = summed >>> DROP;
        end else begin : g_plain
            assign scaled = ext;
        end
    endgenerate

    assign upper = scaled[EW-1:OUT_W-1];
    assign clamp = !((&upper) || !(|upper));

    always_comb begin
        if (!clamp)
            dout = scaled[OUT_W-1:0];
        else if (scaled[EW-1])
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        else
            dout = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/qcv_widen.sv
module qcv_widen #(
    parameter int IN_W = 16,
    parameter int SHL  = 15,
    parameter int OW   = 64
) (
    input  logic [IN_W-1:0] din,
    output logic [OW-1:0]   dout
);
    logic [OW-1:0] sext;
    assign sext = {{(OW-IN_W){din[IN_W-1]}}, din};
    assign dout = sext << SHL;
endmodule

// File: rtl/qcv_narrow.sv
module qcv_narrow
    import qcv_pkg::*;
(
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    output logic [DW-1:0] to_h,
    output logic          to_h_clamp,
    output logic [DW-1:0] to_w,
    output logic          to_w_clamp
);
    logic [QW-1:0] lane_h;
    logic [HW-1:0] lane_w;

    qcv_lane_sat #(.IN_W(DW), .DROP(FRAC_Q62 - FRAC_Q15), .OUT_W(QW), .PRE_SHL(0)) u_h (
        .din(src), .dout(lane_h), .clamp(to_h_clamp)
    );
    qcv_lane_sat #(.IN_W(DW), .DROP(FRAC_Q62 - FRAC_Q31), .OUT_W(HW), .PRE_SHL(0)) u_w (
        .din(src), .dout(lane_w), .clamp(to_w_clamp)
    );

    assign to_h = {dst[DW-1:QW], lane_h};
    assign to_w = {dst[DW-1:HW], lane_w};
endmodule

// File: rtl/qcv_pack.sv
module qcv_pack
    import qcv_pkg::*;
(
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] rnd_out,
    output logic          rnd_clamp,
    output logic [DW-1:0] int_out,
    output logic          int_clamp,
    output logic [DW-1:0] dbl_out,
    output logic          dbl_clamp
);
    localparam int NQ = DW / HW * 2;   // 32-bit lanes across both sources
    localparam int NP = 2;             // whole-source lanes

    logic [NQ-1:0][HW-1:0] q_in;
    logic [NQ-1:0][QW-1:0] q_out;
    logic [NQ-1:0]         q_clamp;
    logic [NP-1:0][DW-1:0] p_in;
    logic [NP-1:0][HW-1:0] i_out, d_out;
    logic [NP-1:0]         i_clamp, d_clamp;

    // lane order: A low, A high, B low, B high
    assign q_in = {src_b, src_a};
    assign p_in = {src_b, src_a};

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_rnd
            qcv_lane_sat #(.IN_W(HW), .DROP(FRAC_Q31 - FRAC_Q15), .OUT_W(QW), .PRE_SHL(0)) u_l (
                .din(q_in[g]), .dout(q_out[g]), .clamp(q_clamp[g])
            );
        end
        for (genvar g = 0; g < NP; g++) begin : g_pair
            qcv_lane_sat #(.IN_W(DW), .DROP(0), .OUT_W(HW), .PRE_SHL(0)) u_int (
                .din(p_in[g]), .dout(i_out[g]), .clamp(i_clamp[g])
            );
            qcv_lane_sat #(.IN_W(DW), .DROP(0), .OUT_W(HW), .PRE_SHL(1)) u_dbl (
                .din(p_in[g]), .dout(d_out[g]), .clamp(d_clamp[g])
            );
        end
    endgenerate

    assign rnd_out   = q_out;
    assign rnd_clamp = |q_clamp;
    assign int_out   = i_out;
    assign int_clamp = |i_clamp;
    assign dbl_out   = d_out;
    assign dbl_clamp = |d_clamp;
endmodule

// File: rtl/qcv_unit.sv
module qcv_unit
    import qcv_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op,
    input  logic [63:0]   src_a,
    input  logic [63:0]   src_b,
    input  logic [63:0]   dst_in,
    output logic [63:0]   result,
    output logic          sat,
    output logic          sat_sticky,
    output logic          illegal
);
    qop_e          opc;
    logic [DW-1:0] wid_h, wid_w;
    logic [DW-1:0] nar_h, nar_w;
    logic          nar_h_c, nar_w_c;
    logic [DW-1:0] pk_rnd, pk_int, pk_dbl;
    logic          pk_rnd_c, pk_int_c, pk_dbl_c;
    qres_t         nxt;
    logic          sticky_q;

    assign opc = qop_e'(op);

    qcv_widen #(.IN_W(QW), .SHL(FRAC_Q30_SHIFT()), .OW(DW)) u_wid_h (
        .din(src_a[QW-1:0]), .dout(wid_h)
    );
    qcv_widen #(.IN_W(HW), .SHL(FRAC_Q62 - FRAC_Q31), .OW(DW)) u_wid_w (
        .din(src_a[HW-1:0]), .dout(wid_w)
    );

    qcv_narrow u_nar (
        .src(src_a), .dst(dst_in),
        .to_h(nar_h), .to_h_clamp(nar_h_c),
        .to_w(nar_w), .to_w_clamp(nar_w_c)
    );

    qcv_pack u_pack (
        .src_a(src_a), .src_b(src_b),
        .rnd_out(pk_rnd), .rnd_clamp(pk_rnd_c),
        .int_out(pk_int), .int_clamp(pk_int_c),
        .dbl_out(pk_dbl), .dbl_clamp(pk_dbl_c)
    );

    // Q15 -> Q30 gains (30 - 15) fractional bits
    function automatic int FRAC_Q30_SHIFT();
        return 2 * FRAC_Q15 - FRAC_Q15;
    endfunction

    always_comb begin
        nxt = '{data: dst_in, clamp: 1'b0, illegal: 1'b0};
        unique case (opc)
            QOP_WIDEN_H:  nxt.data = wid_h;
            QOP_WIDEN_W:  nxt.data = wid_w;
            QOP_NARROW_H: begin nxt.data = nar_h;  nxt.clamp = nar_h_c;  end
            QOP_NARROW_W: begin nxt.data = nar_w;  nxt.clamp = nar_w_c;  end
            QOP_PACK_RND: begin nxt.data = pk_rnd; nxt.clamp = pk_rnd_c; end
            QOP_PACK_INT: begin nxt.data = pk_int; nxt.clamp = pk_int_c; end
            QOP_PACK_DBL: begin nxt.data = pk_dbl; nxt.clamp = pk_dbl_c; end
            default:      nxt.illegal = 1'b1;
        endcase
        if (!clamps_possible(opc))
            nxt.clamp = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sticky_q <= 1'b0;
        else if (op_valid && nxt.clamp)
            sticky_q <= 1'b1;
    end
    assign sat_sticky = sticky_q;

    generate
        if (REG_OUT) begin : g_reg
            qres_t out_q;
            always_ff @(posedge clk) begin
                if (rst)
                    out_q <= '0;
                else if (op_valid)
                    out_q <= nxt;
            end
            assign result  = out_q.data;
            assign sat     = out_q.clamp;
            assign illegal = out_q.illegal;
        end else begin : g_comb
            assign result  = nxt.data;
            assign sat     = nxt.clamp;
            assign illegal = nxt.illegal;
        end
    endgenerate
endmodule

// File: rtl/qcv_unit_chk.sv
module qcv_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic [63:0] dst_in,
    input logic [63:0] result,
    input logic        sat,
    input logic        sat_sticky,
    input logic        illegal
);
    logic unused_ok;
    assign unused_ok = ^{src_a, src_b};

    generate
        if (REG_OUT) begin : g_chk
            // R1
            a_r1_widen_low_zero: assert property (@(posedge clk) disable iff (rst)
                op_valid && op == 3'd0 |=> result[14:0] == 15'd0);
            // R3
            a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
                op_valid && op == 3'd2 |=> result[63:16] == $past(dst_in[63:16]));
            // R4
            a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
                op_valid && op == 3'd3 |=> result[63:32] == $past(dst_in[63:32]));
            // R9
            a_r9_no_sat_on_plain_ops: assert property (@(posedge clk) disable iff (rst)
                op_valid && (op == 3'd0 || op == 3'd1 || op == 3'd7) |=> !sat);
            // R10
            a_r10_sticky_holds: assert property (@(posedge clk) disable iff (rst)
                sat_sticky |=> sat_sticky);
            a_r10_sticky_covers_sat: assert property (@(posedge clk) disable iff (rst)
                sat |-> sat_sticky);
            // R11
            a_r11_illegal_passes_dst: assert property (@(posedge clk) disable iff (rst)
                op_valid && op == 3'd7 |=> illegal && result == $past(dst_in));
            // R12
            a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
                !op_valid |=> $stable(result) && $stable(sat) && $stable(illegal));
            // R13
            a_r13_reset_clears: assert property (@(posedge clk)
                rst |=> result == 64'd0 && !sat && !illegal && !sat_sticky);
        end
    endgenerate
endmodule

bind qcv_unit qcv_unit_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/qcv_unit_tb.sv
module qcv_unit_tb;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] dst;
        logic [63:0] res;
        logic        sat;
        logic        ill;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R1 widen low halfword
        '{4'd1, 3'd0, 64'h1234_5678_9ABC_8000, 64'h0, 64'h0, 64'hFFFF_FFFF_C000_0000, 1'b0, 1'b0},
        '{4'd1, 3'd0, 64'h0000_0000_0000_7FFF, 64'h0, 64'h0, 64'h0000_0000_3FFF_8000, 1'b0, 1'b0},
        // R2 widen low word
        '{4'd2, 3'd1, 64'hAAAA_AAAA_8000_0000, 64'h0, 64'h0, 64'hC000_0000_0000_0000, 1'b0, 1'b0},
        '{4'd2, 3'd1, 64'h0000_0000_0000_0003, 64'h0, 64'h0, 64'h0000_0001_8000_0000, 1'b0, 1'b0},
        // R3 / R8 exact half rounds up
        '{4'd3, 3'd2, 64'h0000_4000_0000_0000, 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_0001, 1'b0, 1'b0},
        // R3 / R9 positive clamp
        '{4'd3, 3'd2, 64'h4000_0000_0000_0000, 64'h0, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_7FFF, 1'b1, 1'b0},
        // R3 most negative representable, no clamp
        '{4'd3, 3'd2, 64'hC000_0000_0000_0000, 64'h0, 64'h0, 64'h0000_0000_0000_8000, 1'b0, 1'b0},
        // R8 negative exact half rounds toward plus
        '{4'd8, 3'd2, 64'hFFFF_C000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_0000, 1'b0, 1'b0},
        // R8 just below half
        '{4'd8, 3'd2, 64'h0000_3FFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 1'b0, 1'b0},
        // R4 round to Q31
        '{4'd4, 3'd3, 64'h0000_0000_4000_0000, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_0000_0001, 1'b0, 1'b0},
        // R8 / R4 no wrap at top of range
        '{4'd8, 3'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_7FFF_FFFF, 1'b1, 1'b0},
        // R4 / R9 negative clamp
        '{4'd4, 3'd3, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0000_0000_8000_0000, 1'b1, 1'b0},
        // R5 lane order with one clamp
        '{4'd5, 3'd4, 64'h0003_0000_0001_8000, 64'h8000_0000_7FFF_FFFF, 64'h0, 64'h8000_7FFF_0003_0002, 1'b1, 1'b0},
        // R5 negative lanes, no clamp
        '{4'd5, 3'd4, 64'hFFFF_0000_0001_0000, 64'h1234_0000_FFFF_7FFF, 64'h0, 64'h1234_FFFF_FFFF_0001, 1'b0, 1'b0},
        // R6
        '{4'd6, 3'd5, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 64'h0, 64'h7FFF_FFFF_7FFF_FFFF, 1'b1, 1'b0},
        '{4'd6, 3'd5, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'hFFFF_FFFE_8000_0000, 1'b0, 1'b0},
        '{4'd6, 3'd5, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_0000_0005, 64'h0, 64'h0000_0005_8000_0000, 1'b1, 1'b0},
        // R7
        '{4'd7, 3'd6, 64'h0000_0000_2000_0000, 64'h0000_0000_4000_0000, 64'h0, 64'h7FFF_FFFF_4000_0000, 1'b1, 1'b0},
        '{4'd7, 3'd6, 64'hFFFF_FFFF_C000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFE_8000_0000, 1'b0, 1'b0},
        '{4'd7, 3'd6, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0000_0000_8000_0000, 1'b1, 1'b0},
        // R11 illegal
        '{4'd11, 3'd7, 64'h5555_5555_5555_5555, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] src_a = '0, src_b = '0, dst_in = '0;
    logic [63:0] result;
    logic        sat, sat_sticky, illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    qcv_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
        .result(result), .sat(sat), .sat_sticky(sat_sticky), .illegal(illegal)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, one issuing edge, sample at next falling edge
    task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
        op = o; src_a = a; src_b = b; dst_in = d; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 3000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 result", result, 64'd0);
        chk("R13 sticky", {63'd0, sat_sticky}, 64'd0);
        chk("R13 illegal", {63'd0, illegal}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R10 non-clamping op leaves sticky clear
        issue(3'd5, 64'd7, 64'd9, 64'd0);
        chk("R10 sticky stays clear", {63'd0, sat_sticky}, 64'd0);
        chk("R6 small ints", result, 64'h0000_0009_0000_0007);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].dst);
            n_chk++;
            if (result !== VECS[i].res || sat !== VECS[i].sat || illegal !== VECS[i].ill) begin
                n_bad++;
                $display("FAIL R%0d vec %0d actual=%h/%b/%b expected=%h/%b/%b",
                         VECS[i].req, i, result, sat, illegal,
                         VECS[i].res, VECS[i].sat, VECS[i].ill);
            end
        end

        // R10 sticky set by earlier clamps, survives a clean op
        issue(3'd0, 64'd1, 64'd0, 64'd0);
        chk("R10 sticky kept", {63'd0, sat_sticky}, 64'd1);
        chk("R9 sat clear on widen", {63'd0, sat}, 64'd0);
        chk("R1 widen one", result, 64'h0000_0000_0000_8000);

        // R12 idle inputs do not disturb outputs
        op = 3'd6; src_a = 64'h8000_0000_0000_0000; src_b = '1; dst_in = '1;
        repeat (3) @(negedge clk);
        chk("R12 hold result", result, 64'h0000_0000_0000_8000);
        chk("R12 hold sat", {63'd0, sat}, 64'd0);

        // R12 one-cycle latency: before the edge the old value remains
        op = 3'd7; dst_in = 64'hFEED_FACE_0BAD_F00D; op_valid = 1'b1;
        #1;
        chk("R12 pre-edge", result, 64'h0000_0000_0000_8000);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R11 after edge", result, 64'hFEED_FACE_0BAD_F00D);
        chk("R11 flag", {63'd0, illegal}, 64'd1);

        // R13 reset clears sticky
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R13 sticky cleared", {63'd0, sat_sticky}, 64'd0);
        chk("R13 result cleared", result, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule